// File: doc/BRIEF.md
# Scatter-Gather Descriptor Fetch Unit

This block is the front end of a scatter-gather DMA channel. It holds the channel's run/stop control, its status word and the current-descriptor pointer. While the channel runs, it reads one descriptor from memory at that pointer. The read goes over a simple request/response port that returns a 2-bit response code with every 32-bit word. The unit unpacks the descriptor into a buffer address, a next-descriptor pointer, a control word and a status word. It hands them on to the data engine with a one-cycle valid pulse, and then waits for a strobe before it follows the chain.

A fetch can end in three ways. If any word comes back with a bad response, the unit records the kind of error, stops the channel at once and raises the error interrupt flag; the rest of the descriptor is neither read nor used. If the descriptor is intact but its status word is already marked complete, the channel halts without passing it on. Otherwise the fields are presented on the outputs.

Software-facing register bits appear as plain ports: strobes for setting and clearing run/stop, a pointer write, and a write-one-to-clear vector for the status word.

Top module: `sg_desc_fetch`

## Requirements
- R1: After reset the outputs are as follows: run_stop is 0, dma_status equals 32'h1 (only the halted bit 0 set), cur_desc is 0, and rd_req_valid and desc_valid are 0.
- R2: A runstop_set strobe makes run_stop 1 and clears halted (bit 0) on the next edge. One edge later a read request appears at cur_desc. No read request is issued while halted is 1.
- R3: A descriptor is read as six 32-bit words at cur_desc+0, +4, +8, +12, +16 and +20, in that order: buffer address low, buffer address high, next pointer low, next pointer high, control, status. A new request is issued only after the previous word's response has arrived.
- R4: After the sixth good word, desc_valid is high for exactly one cycle. In that cycle desc_buf_addr = {word1,word0}, desc_next_ptr = {word3,word2}, desc_ctrl = word4 and desc_stat = word5. While the unit waits for the next strobe, dma_status bit 1 (idle) is 1.
- R5: In that wait, a desc_next_req strobe loads cur_desc with desc_next_ptr and starts a fetch there.
- R6: Response code 2'b11 is a decode error and sets dma_status bit 6. Code 2'b00 means OK.
- R7: Response codes 2'b01 and 2'b10 are slave errors and set dma_status bit 5.
- R8: On any bad response, one edge clears run_stop and sets halted (bit 0) and the error interrupt (bit 14). After that the unit issues no request and no desc_valid pulse.
- R9: If the sixth word is good and has bit 31 (complete) set, halted becomes 1, run_stop stays 1, no desc_valid pulse is raised and no further request is issued.
- R10: Bits 5, 6 and 14 stay set until status_w1c carries a 1 in that same bit. A 1 at any other position of status_w1c leaves them unchanged, and status_w1c never clears halted.
- R11: ptr_we loads cur_desc from ptr_wdata only while halted is 1. Otherwise the write is ignored.
- R12: A runstop_clr strobe clears run_stop. If this happens while the unit waits for the next strobe, halted is set, idle drops, and a later desc_next_req starts no fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| runstop_set | input | 1 | Strobe: set run/stop and clear halted |
| runstop_clr | input | 1 | Strobe: clear run/stop |
| ptr_we | input | 1 | Pointer write strobe (accepted only while halted) |
| ptr_wdata | input | AW | New current-descriptor pointer |
| status_w1c | input | 32 | Write-one-to-clear vector for the sticky status bits |
| desc_next_req | input | 1 | Strobe: follow the chain to the next descriptor |
| run_stop | output | 1 | Run/stop control bit |
| dma_status | output | 32 | Status word (0 halted, 1 idle, 5 slave error, 6 decode error, 14 error interrupt) |
| cur_desc | output | AW | Current-descriptor pointer |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | AW | Read word address |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | 32 | Read response word |
| rd_rsp_code | input | 2 | Response code: 00 OK, 01/10 slave error, 11 decode error |
| desc_valid | output | 1 | One-cycle pulse: descriptor fields valid |
| desc_buf_addr | output | 64 | Buffer address field |
| desc_next_ptr | output | 64 | Next-descriptor pointer field |
| desc_ctrl | output | 32 | Control field |
| desc_stat | output | 32 | Status field |

## Verification
A corrupted fetch state shows at the ports within one word: a wrong beat counter gives a wrong rd_req_addr on the very next request, and a lost abort shows as a request issued right after a bad response. A wrong error classification or a sticky bit that was dropped shows in dma_status on the edge after the response, or in the first idle cycle after an unrelated clear strobe. A wrong halt decision shows as a missing or extra desc_valid pulse, or as a fetch that starts after a completed or failed descriptor.

// File: rtl/sg_desc_fetch.sv
module sg_desc_fetch #(
  parameter int AW       = 64,
  parameter int CMPL_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          runstop_set,
  input  logic          runstop_clr,
  input  logic          ptr_we,
  input  logic [AW-1:0] ptr_wdata,
  input  logic [31:0]   status_w1c,
  input  logic          desc_next_req,
  output logic          run_stop,
  output logic [31:0]   dma_status,
  output logic [AW-1:0] cur_desc,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [31:0]   rd_rsp_data,
  input  logic [1:0]    rd_rsp_code,
  output logic          desc_valid,
  output logic [63:0]   desc_buf_addr,
  output logic [63:0]   desc_next_ptr,
  output logic [31:0]   desc_ctrl,
  output logic [31:0]   desc_stat
);
  localparam int NBEAT    = 6;
  localparam int BW       = $clog2(NBEAT);
  localparam int B_HALT   = 0;
  localparam int B_IDLE   = 1;
  localparam int B_SLV    = 5;
  localparam int B_DEC    = 6;
  localparam int B_IRQERR = 14;
  localparam logic [1:0] RSP_OK  = 2'b00;
  localparam logic [1:0] RSP_DEC = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_HOLD} st_t;

  st_t            st;
  logic [BW-1:0]  beat;
  logic [31:0]    w [NBEAT];
  logic           halted, slverr, decerr, irq_err;

  logic taking, rsp_bad, rsp_ok, last, fetched, cmpl, go, parked;
  assign taking  = (st == S_WAIT) && rd_rsp_valid;
  assign rsp_bad = taking && (rd_rsp_code != RSP_OK);
  assign rsp_ok  = taking && (rd_rsp_code == RSP_OK);
  assign last    = (beat == BW'(NBEAT-1));
  assign fetched = rsp_ok && last;
  assign cmpl    = rd_rsp_data[CMPL_BIT];
  assign go      = run_stop && !halted;
  assign parked  = (st == S_IDLE) || (st == S_HOLD);

  logic unused_w1c;
  assign unused_w1c = ^{status_w1c[31:B_IRQERR+1], status_w1c[B_IRQERR-1:B_DEC+1],
                        status_w1c[B_SLV-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      beat     <= '0;
      cur_desc <= '0;
    end else begin
      if (ptr_we && halted) cur_desc <= ptr_wdata;
      case (st)
        S_IDLE: if (go) begin
          st   <= S_REQ;
          beat <= '0;
        end
        S_REQ: if (rd_req_ready) st <= S_WAIT;
        S_WAIT: begin
          if (rsp_bad) st <= S_IDLE;
          else if (rsp_ok) begin
            if (!last) begin
              beat <= beat + 1'b1;
              st   <= S_REQ;
            end else begin
              st <= cmpl ? S_IDLE : S_HOLD;
            end
          end
        end
        S_HOLD: begin
          if (!run_stop) st <= S_IDLE;
          else if (desc_next_req) begin
            cur_desc <= desc_next_ptr[AW-1:0];
            beat     <= '0;
            st       <= S_REQ;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_stop <= 1'b0;
      halted   <= 1'b1;
      slverr   <= 1'b0;
      decerr   <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      if (rsp_bad)          run_stop <= 1'b0;
      else if (runstop_set) run_stop <= 1'b1;
      else if (runstop_clr) run_stop <= 1'b0;

      if (rsp_bad || (fetched && cmpl)) halted <= 1'b1;
      else if (runstop_set)             halted <= 1'b0;
      else if (parked && !run_stop)     halted <= 1'b1;

      slverr  <= (slverr  & ~status_w1c[B_SLV])    | (rsp_bad && rd_rsp_code != RSP_DEC);
      decerr  <= (decerr  & ~status_w1c[B_DEC])    | (rsp_bad && rd_rsp_code == RSP_DEC);
      irq_err <= (irq_err & ~status_w1c[B_IRQERR]) | rsp_bad;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) desc_valid <= 1'b0;
    else        desc_valid <= fetched && !cmpl;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBEAT; i++) w[i] <= '0;
    end else begin
      for (int i = 0; i < NBEAT; i++)
        if (rsp_ok && beat == BW'(i)) w[i] <= rd_rsp_data;
    end
  end

  assign rd_req_valid  = (st == S_REQ);
  assign rd_req_addr   = cur_desc + {{(AW-BW-2){1'b0}}, beat, 2'b00};
  assign desc_buf_addr = {w[1], w[0]};
  assign desc_next_ptr = {w[3], w[2]};
  assign desc_ctrl     = w[4];
  assign desc_stat     = w[5];

  always_comb begin
    dma_status           = '0;
    dma_status[B_HALT]   = halted;
    dma_status[B_IDLE]   = (st == S_HOLD);
    dma_status[B_SLV]    = slverr;
    dma_status[B_DEC]    = decerr;
    dma_status[B_IRQERR] = irq_err;
  end
endmodule

// File: rtl/sg_desc_fetch_chk.sv
module sg_desc_fetch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_v,
  input logic       req_rdy,
  input logic       rsp_v,
  input logic [1:0] rsp_code,
  input logic       run_stop,
  input logic       st_halted,
  input logic       st_slv,
  input logic       st_dec,
  input logic       st_irq_err,
  input logic       w1c_err,
  input logic       desc_valid
);
  logic pend;
  always_ff @(posedge clk) begin
    if (!rst_n)                pend <= 1'b0;
    else if (req_v && req_rdy) pend <= 1'b1;
    else if (rsp_v)            pend <= 1'b0;
  end

  logic bad;
  assign bad = pend && rsp_v && (rsp_code != 2'b00);

  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !req_v);
  p_halted_no_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_halted |-> !req_v);
  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |=> !desc_valid);
  p_dec_class_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad && rsp_code == 2'b11 |=> st_dec);
  p_slv_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bad && rsp_code != 2'b11 |=> st_slv);
  p_err_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> !run_stop && st_halted && st_irq_err);
  p_err_aborts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> !req_v && !desc_valid);
  p_sticky_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st_irq_err && !w1c_err |=> st_irq_err);
endmodule

bind sg_desc_fetch sg_desc_fetch_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_v      (rd_req_valid),
  .req_rdy    (rd_req_ready),
  .rsp_v      (rd_rsp_valid),
  .rsp_code   (rd_rsp_code),
  .run_stop   (run_stop),
  .st_halted  (dma_status[0]),
  .st_slv     (dma_status[5]),
  .st_dec     (dma_status[6]),
  .st_irq_err (dma_status[14]),
  .w1c_err    (status_w1c[14]),
  .desc_valid (desc_valid)
);

// File: tb/tb_sg_desc_fetch.sv
module tb_sg_desc_fetch;
  localparam int AW = 64;
  localparam int NV = 5;
  // kind: 0 valid, 1 slave error, 2 decode error, 3 already complete
  localparam logic [31:0] TW [NV][6] = '{
    '{32'h1111_0000, 32'h0000_00AB, 32'h0000_2000, 32'h0000_00CD, 32'h8000_0400, 32'h0000_0001},
    '{32'h2222_0010, 32'h0000_0001, 32'h3000_0040, 32'h0000_0000, 32'h0000_0100, 32'h0000_0000},
    '{32'h3333_0020, 32'h0000_0002, 32'h4000_0080, 32'h0000_0000, 32'h0000_0200, 32'h0000_0000},
    '{32'h4444_0030, 32'h0000_0003, 32'h5000_00C0, 32'h0000_0000, 32'h0000_0300, 32'h8000_0012},
    '{32'h5555_0040, 32'h0000_0004, 32'h6000_0100, 32'h0000_0000, 32'h0000_0400, 32'h0000_0000}};
  localparam int         TEB   [NV] = '{6, 2, 0, 6, 5};
  localparam logic [1:0] TEC   [NV] = '{2'b00, 2'b11, 2'b10, 2'b00, 2'b01};
  localparam int         TKIND [NV] = '{0, 2, 1, 3, 1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic runstop_set = 0, runstop_clr = 0, ptr_we = 0, desc_next_req = 0;
  logic [AW-1:0] ptr_wdata = '0;
  logic [31:0] status_w1c = '0;
  logic rd_req_ready = 1'b1;
  logic rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic [1:0] rd_rsp_code = 2'b00;
  logic run_stop, rd_req_valid, desc_valid;
  logic [31:0] dma_status, desc_ctrl, desc_stat;
  logic [AW-1:0] cur_desc, rd_req_addr;
  logic [63:0] desc_buf_addr, desc_next_ptr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sg_desc_fetch #(.AW(AW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_set();   runstop_set = 1;   @(negedge clk); runstop_set = 0;   endtask
  task automatic pulse_clr();   runstop_clr = 1;   @(negedge clk); runstop_clr = 0;   endtask
  task automatic pulse_next();  desc_next_req = 1; @(negedge clk); desc_next_req = 0; endtask

  task automatic restart(input logic [63:0] base);
    pulse_clr();
    repeat (2) @(negedge clk);
    ptr_wdata = base; ptr_we = 1;
    @(negedge clk); ptr_we = 0;
    status_w1c = '1;
    @(negedge clk); status_w1c = '0;
    chk(cur_desc == base, "R11 load while halted", cur_desc, base);
    chk(dma_status[0] == 1'b1, "R2 halted before start", dma_status, 1);
    pulse_set();
    chk(run_stop && !dma_status[0], "R2 set clears halted", {run_stop, dma_status[0]}, 2'b10);
    @(negedge clk);
    chk(rd_req_valid && rd_req_addr == base, "R2 first request", rd_req_addr, base);
  endtask

  task automatic quiet(input int n, input string tag);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (rd_req_valid || desc_valid) seen = 1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic run_vec(input int v, input logic [63:0] base);
    bit stopped = 0;
    int kind = TKIND[v];
    for (int b = 0; b < 6 && !stopped; b++) begin
      int n = 0;
      while (!rd_req_valid && n < 16) begin @(negedge clk); n++; end
      chk(rd_req_valid && rd_req_addr == base + 64'(4*b), "R3 word address", rd_req_addr, base + 64'(4*b));
      if (!rd_req_valid) stopped = 1;
      else begin
        @(negedge clk);
        rd_rsp_valid = 1; rd_rsp_data = TW[v][b];
        rd_rsp_code = (b == TEB[v]) ? TEC[v] : 2'b00;
        @(negedge clk);
        rd_rsp_valid = 0; rd_rsp_code = 2'b00;
        if (b == TEB[v]) stopped = 1;
      end
    end
    if (kind == 0) begin
      chk(desc_valid == 1'b1, "R4 valid pulse", desc_valid, 1);
      chk(desc_buf_addr == {TW[v][1], TW[v][0]}, "R4 buffer field", desc_buf_addr, {TW[v][1], TW[v][0]});
      chk(desc_next_ptr == {TW[v][3], TW[v][2]}, "R4 next field", desc_next_ptr, {TW[v][3], TW[v][2]});
      chk(desc_ctrl == TW[v][4] && desc_stat == TW[v][5], "R4 ctrl/status fields",
          {desc_ctrl, desc_stat}, {TW[v][4], TW[v][5]});
      chk(dma_status[1] == 1'b1, "R4 idle bit", dma_status, 2);
      @(negedge clk);
      chk(desc_valid == 1'b0, "R4 single cycle", desc_valid, 0);
    end else if (kind == 3) begin
      chk(dma_status[0] && run_stop, "R9 halted, run kept", {dma_status[0], run_stop}, 2'b11);
      chk(!desc_valid && !dma_status[14], "R9 no pulse no error", {desc_valid, dma_status[14]}, 0);
      quiet(6, "R9 walk stops");
    end else begin
      chk(!run_stop && dma_status[0] && dma_status[14], "R8 halt and error irq",
          {run_stop, dma_status[0], dma_status[14]}, 3'b011);
      chk(dma_status[5] == (kind == 1), "R7 slave error bit", dma_status[5], kind == 1);
      chk(dma_status[6] == (kind == 2), "R6 decode error bit", dma_status[6], kind == 2);
      chk(!desc_valid, "R8 no descriptor", desc_valid, 0);
      quiet(6, "R8 walk aborted");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all-R act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] b0, nxt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(run_stop == 0 && dma_status == 32'h1, "R1 control/status", {run_stop, dma_status}, 33'h1);
    chk(!rd_req_valid && !desc_valid && cur_desc == 0, "R1 idle outputs",
        {rd_req_valid, desc_valid, cur_desc}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [63:0] base = 64'h0000_00A5_0000_1000 + 64'(v) * 64'h100;
      restart(base);
      run_vec(v, base);
    end

    b0 = 64'h0000_00A5_0000_8000;
    restart(b0);
    run_vec(0, b0);
    ptr_wdata = 64'hDEAD_BEEF_0000_0000; ptr_we = 1;
    @(negedge clk); ptr_we = 0;
    chk(cur_desc == b0, "R11 write ignored while running", cur_desc, b0);
    nxt = {TW[0][3], TW[0][2]};
    pulse_next();
    run_vec(0, nxt);
    chk(cur_desc == nxt, "R5 pointer follows chain", cur_desc, nxt);

    pulse_clr();
    repeat (2) @(negedge clk);
    chk(!run_stop && dma_status[0] && !dma_status[1], "R12 clear halts",
        {run_stop, dma_status[1:0]}, 3'b001);
    pulse_next();
    quiet(6, "R12 no fetch after clear");

    restart(b0);
    run_vec(1, b0);
    repeat (3) @(negedge clk);
    chk(dma_status[6] && dma_status[14], "R10 bits stay set", dma_status, 32'h4041);
    status_w1c = 32'h0000_2020;
    @(negedge clk); status_w1c = '0;
    chk(dma_status[6] && dma_status[14], "R10 other bits no effect", dma_status, 32'h4041);
    status_w1c = 32'h0000_0040;
    @(negedge clk); status_w1c = '0;
    chk(!dma_status[6] && dma_status[14], "R10 clear bit 6 only", dma_status, 32'h4001);
    status_w1c = 32'h0000_4001;
    @(negedge clk); status_w1c = '0;
    chk(dma_status == 32'h1, "R10 clear irq, halted kept", dma_status, 32'h1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule